// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block gives a debug host access to the nine 32-bit registers of an on-chip trace buffer through one JTAG data register. The TAP controller outside the block supplies three strobes: capture, shift and update. The data register is a 40-bit shift frame that moves LSB-first. Bits 31:0 carry a data word, bits 38:32 a register address, and bit 39 a direction flag, where 1 means write and 0 means read.

On every update the block decodes the frame. A write stores the data word into the addressed register if that register is writable. A read copies the addressed register into a hold latch, and the next capture loads that latch into the data field, so read data always comes back one scan late. A host therefore needs two scans per register read, and the second scan usually addresses the identification register so that it has no side effects. Address 4 is a window onto the buffer RAM. Each read there returns the word at the read pointer and moves the pointer on by one, so back-to-back scans at address 4 stream consecutive RAM words.

The block drives the current read pointer to the buffer core as the RAM address, takes the RAM word and the status flags back, and drives the control, write-pointer and trigger-count values to the core.

Top module: `scan_reg_port`

## Requirements
- R1: After synchronous reset, the read pointer, write pointer, trigger count, control register and read hold latch are all zero, so the first scan returns a zero data field.
- R2: The frame shifts LSB-first: tdi enters at bit 39, tdo is bit 0, and the frame holds data in bits 31:0, address in bits 38:32 and the direction flag in bit 39. On capture, bits 39:32 load as zero.
- R3: An update with flag 1 at address 8 (control) or address 7 (trigger count) stores the 32-bit data word. The new value appears on the matching output in the cycle after the update.
- R4: An update with flag 0 latches the addressed register, and that value is returned in bits 31:0 of the next scan.
- R5: Addresses 0 (identification, a parameter value), 1 (RAM depth), 2 (RAM word width, 32), 3 (status) and 4 (RAM data) ignore writes. Reading them back afterwards shows no change.
- R6: A read at address 4 returns ram_rdata for the current read pointer and adds exactly one to the pointer per update. The pointer wraps from DEPTH-1 to 0.
- R7: Addresses 9 to 127 read as zero, and writes to them change no register.
- R8: A read at address 3 returns the 4-bit status input zero-extended to 32 bits.
- R9: A write to address 5 (read pointer) or address 6 (write pointer) keeps only the low log2(DEPTH) bits. A read of those addresses returns the pointer zero-extended.
- R10: Capture and shift cycles with no update leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe: load read latch into frame |
| shift_en | input | 1 | Shift strobe: move frame one bit toward tdo |
| upd_en | input | 1 | Update strobe: decode and act on frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| status_i | input | 4 | Status flags from buffer core |
| ram_rdata | input | 32 | RAM word at ram_raddr |
| ram_raddr | output | PTR_W | Current read pointer |
| wr_ptr_o | output | PTR_W | Write pointer value |
| trig_o | output | 32 | Trigger count value |
| ctrl_o | output | 32 | Control register value |

## Verification
A wrong read pointer shows on ram_raddr in the cycle after the update that caused it. It also shows in the next scan's data field as the wrong RAM word. A stale or wrongly selected hold latch is seen only one scan later, because reads are pipelined, so every scan compares its shifted-out frame with the value the model latched on the previous update. A pointer that moves once per shifted bit instead of once per update would diverge on ram_raddr within one shift cycle, and the output compare runs every clock.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
    localparam int FRAME_W = 40;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [ADDR_W-1:0] {
        A_IDENT  = 7'd0,
        A_DEPTH  = 7'd1,
        A_WIDTH  = 7'd2,
        A_STATUS = 7'd3,
        A_RAM    = 7'd4,
        A_RDPTR  = 7'd5,
        A_WRPTR  = 7'd6,
        A_TRIG   = 7'd7,
        A_CTRL   = 7'd8
    } reg_addr_e;

    function automatic logic [DATA_W-1:0] zext(input logic [DATA_W-1:0] v);
        return v;
    endfunction
endpackage

// File: rtl/scan_shifter.sv
module scan_shifter
    import scan_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_word,
    output logic              tdo,
    output frame_t            frame_o
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (cap_en)
            sr_q <= {{(FRAME_W-DATA_W){1'b0}}, cap_word};
        else if (shift_en)
            sr_q <= {tdi, sr_q[FRAME_W-1:1]};
    end

    assign tdo     = sr_q[0];
    assign frame_o = frame_t'(sr_q);

    // R2
    shift_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !cap_en) |=> (sr_q[FRAME_W-2:0] == $past(sr_q[FRAME_W-1:1])));
    // R2
    cap_top_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (frame_o.wr == 1'b0 && frame_o.addr == '0));
endmodule

// File: rtl/scan_regfile.sv
module scan_regfile
    import scan_port_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter logic [31:0] ID_VALUE = 32'h4E75_0A11,
    localparam int         PTR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  frame_t            frame,
    input  logic [3:0]        status_i,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] latch_o,
    output logic [PTR_W-1:0]  rd_ptr_o,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic [DATA_W-1:0] trig_o,
    output logic [DATA_W-1:0] ctrl_o
);
    logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
    logic [DATA_W-1:0] trig_q, ctrl_q, latch_q, rd_val;
    logic              do_wr, do_rd;

    assign do_wr = upd_en &&  frame.wr;
    assign do_rd = upd_en && !frame.wr;

    always_comb begin
        case (frame.addr)
            A_IDENT:  rd_val = ID_VALUE;
            A_DEPTH:  rd_val = DATA_W'(DEPTH);
            A_WIDTH:  rd_val = DATA_W'(DATA_W);
            A_STATUS: rd_val = zext({28'd0, status_i});
            A_RAM:    rd_val = ram_rdata;
            A_RDPTR:  rd_val = DATA_W'(rd_ptr_q);
            A_WRPTR:  rd_val = DATA_W'(wr_ptr_q);
            A_TRIG:   rd_val = trig_q;
            A_CTRL:   rd_val = ctrl_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            trig_q   <= '0;
            ctrl_q   <= '0;
            latch_q  <= '0;
        end else if (do_wr) begin
            case (frame.addr)
                A_RDPTR: rd_ptr_q <= frame.data[PTR_W-1:0];
                A_WRPTR: wr_ptr_q <= frame.data[PTR_W-1:0];
                A_TRIG:  trig_q   <= frame.data;
                A_CTRL:  ctrl_q   <= frame.data;
                default: ;
            endcase
        end else if (do_rd) begin
            latch_q <= rd_val;
            if (frame.addr == A_RAM)
                rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    assign latch_o  = latch_q;
    assign rd_ptr_o = rd_ptr_q;
    assign wr_ptr_o = wr_ptr_q;
    assign trig_o   = trig_q;
    assign ctrl_o   = ctrl_q;

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (do_rd && frame.addr == A_RAM) |=> (rd_ptr_q == PTR_W'($past(rd_ptr_q) + 1'b1)));
    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(rd_ptr_q));
    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !do_rd |=> $stable(latch_q));
    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(do_wr && frame.addr == A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
    import scan_port_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter logic [31:0] ID_VALUE = 32'h4E75_0A11,
    localparam int         PTR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              upd_en,
    input  logic              tdi,
    output logic              tdo,
    input  logic [3:0]        status_i,
    input  logic [31:0]       ram_rdata,
    output logic [PTR_W-1:0]  ram_raddr,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic [31:0]       trig_o,
    output logic [31:0]       ctrl_o
);
    frame_t            frame;
    logic [DATA_W-1:0] latch;

    scan_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .tdi      (tdi),
        .cap_word (latch),
        .tdo      (tdo),
        .frame_o  (frame)
    );

    scan_regfile #(.DEPTH(DEPTH), .ID_VALUE(ID_VALUE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .frame     (frame),
        .status_i  (status_i),
        .ram_rdata (ram_rdata),
        .latch_o   (latch),
        .rd_ptr_o  (ram_raddr),
        .wr_ptr_o  (wr_ptr_o),
        .trig_o    (trig_o),
        .ctrl_o    (ctrl_o)
    );
endmodule

// File: tb/tb_scan_reg_port.sv
`timescale 1ns/1ps
module tb_scan_reg_port;
    localparam int          DEPTH = 16;
    localparam int          PW    = 4;
    localparam logic [31:0] IDV   = 32'h4E75_0A11;

    logic clk = 0, rst = 1, cap_en = 0, shift_en = 0, upd_en = 0, tdi = 0;
    logic tdo;
    logic [3:0]  status_i = 4'b1010;
    logic [31:0] ram_rdata, trig_o, ctrl_o;
    logic [PW-1:0] ram_raddr, wr_ptr_o;

    int checks = 0, fails = 0;

    // model state
    int unsigned m_rp = 0, m_wp = 0;
    logic [31:0] m_trig = 0, m_ctrl = 0, m_latch = 0;

    always #5 clk = ~clk;

    assign ram_rdata = 32'hC0DE_0000 | (32'(ram_raddr) * 32'd3 + 32'd1);

    scan_reg_port #(.DEPTH(DEPTH), .ID_VALUE(IDV)) dut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .tdi(tdi), .tdo(tdo), .status_i(status_i), .ram_rdata(ram_rdata),
        .ram_raddr(ram_raddr), .wr_ptr_o(wr_ptr_o), .trig_o(trig_o), .ctrl_o(ctrl_o)
    );

    function automatic logic [31:0] ram_word(int unsigned a);
        return 32'hC0DE_0000 | (32'(a) * 32'd3 + 32'd1);
    endfunction

    function automatic logic [31:0] model_read(int a);
        case (a)
            0: return IDV;
            1: return 32'(DEPTH);
            2: return 32'd32;
            3: return {28'd0, status_i};
            4: return ram_word(m_rp);
            5: return 32'(m_rp);
            6: return 32'(m_wp);
            7: return m_trig;
            8: return m_ctrl;
            default: return 32'd0;
        endcase
    endfunction

    task automatic apply_model(bit wr, int a, logic [31:0] d);
        if (wr) begin
            case (a)
                5: m_rp = d % DEPTH;
                6: m_wp = d % DEPTH;
                7: m_trig = d;
                8: m_ctrl = d;
                default: ;
            endcase
        end else begin
            m_latch = model_read(a);
            if (a == 4) m_rp = (m_rp + 1) % DEPTH;
        end
    endtask

    // per-clock compare of core-facing outputs (R3 R6 R9 R10)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (ram_raddr != PW'(m_rp) || wr_ptr_o != PW'(m_wp) ||
                trig_o != m_trig || ctrl_o != m_ctrl) begin
                fails++;
                $display("FAIL R3/R6/R9/R10 outputs: got rp=%0d wp=%0d trig=%h ctrl=%h exp rp=%0d wp=%0d trig=%h ctrl=%h",
                         ram_raddr, wr_ptr_o, trig_o, ctrl_o, m_rp, m_wp, m_trig, m_ctrl);
            end
        end
    end

    // one scan: capture, 40 shifts, optional update; checks the returned frame
    task automatic scan(bit wr, int a, logic [31:0] d, bit do_upd, string tag);
        logic [39:0] fr, got, exp;
        fr  = {wr, 7'(a), d};
        exp = {8'd0, m_latch};
        @(negedge clk) cap_en = 1;
        @(negedge clk) cap_en = 0;
        shift_en = 1;
        for (int i = 0; i < 40; i++) begin
            tdi = fr[i];
            got[i] = tdo;
            @(negedge clk);
        end
        shift_en = 0;
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s frame: got %h exp %h", tag, got, exp);
        end
        if (do_upd) begin
            upd_en = 1;
            @(posedge clk);
            #1 apply_model(wr, a, d);
            @(negedge clk) upd_en = 0;
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        checks++;
        if (ctrl_o !== 0 || ram_raddr !== 0 || trig_o !== 0 || wr_ptr_o !== 0) begin
            fails++;
            $display("FAIL R1 reset: got ctrl=%h rp=%0d exp 0", ctrl_o, ram_raddr);
        end
        scan(0, 0, 32'h0, 1, "R1");           // returns zero latch
        scan(0, 1, 32'h0, 1, "R4");           // returns ident
        scan(0, 2, 32'h0, 1, "R5");           // returns depth
        scan(0, 3, 32'h0, 1, "R5");           // returns width
        scan(0, 0, 32'h0, 1, "R8");           // returns status
        // R3 writes
        scan(1, 8, 32'hDEAD_BEEF, 1, "R3");
        scan(1, 7, 32'h0000_0064, 1, "R3");
        scan(0, 8, 32'h0, 1, "R3");
        scan(0, 7, 32'h0, 1, "R3");
        // R5 read-only writes ignored
        scan(1, 0, 32'h1111_1111, 1, "R5");
        scan(1, 1, 32'h2222_2222, 1, "R5");
        scan(1, 3, 32'h3333_3333, 1, "R5");
        scan(1, 4, 32'h4444_4444, 1, "R5");
        scan(0, 0, 32'h0, 1, "R5");
        scan(0, 1, 32'h0, 1, "R5");
        scan(0, 5, 32'h0, 1, "R5");
        // R9 pointer masking
        scan(1, 5, 32'h0000_0023, 1, "R9");
        scan(1, 6, 32'hFFFF_FFF9, 1, "R9");
        scan(0, 6, 32'h0, 1, "R9");
        scan(0, 5, 32'h0, 1, "R9");
        // R6 streaming reads
        for (int k = 0; k < 4; k++) scan(0, 4, 32'h0, 1, "R6");
        scan(0, 0, 32'h0, 1, "R6");
        scan(1, 5, 32'd15, 1, "R6");
        scan(0, 4, 32'h0, 1, "R6");
        scan(0, 4, 32'h0, 1, "R6");            // wraps to 0
        scan(0, 5, 32'h0, 1, "R6");
        scan(0, 0, 32'h0, 1, "R6");
        // R7 unmapped
        scan(1, 9, 32'hAAAA_5555, 1, "R7");
        scan(1, 127, 32'h5555_AAAA, 1, "R7");
        scan(0, 9, 32'h0, 1, "R7");
        scan(0, 127, 32'h0, 1, "R7");
        scan(0, 8, 32'h0, 1, "R7");
        // R10 capture/shift without update
        scan(1, 8, 32'h0BAD_F00D, 0, "R10");
        scan(0, 4, 32'h0, 0, "R10");
        scan(0, 8, 32'h0, 1, "R10");
        scan(0, 5, 32'h0, 1, "R10");
        // R2 bit order: distinct status pattern read back
        status_i = 4'b0101;
        scan(0, 3, 32'h0, 1, "R2");
        scan(0, 0, 32'h0, 1, "R2");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule